// File: doc/BRIEF.md
# Host Port Request Flag Controller

This block drives the single request line that a device presents to a host on a byte-wide message port. The line is shared by two directions of traffic. In read mode it goes low when the outbound buffer holds data for the host. In write mode it goes high when the inbound buffer has room for another byte. So the active level of the line flips with the mode.

The mode is never written directly. It follows from the most recent command byte the host wrote. Four opcodes select read mode, two select write mode, and every other opcode leaves the mode alone.

A rising edge on the host's read/write direction input pulls the request line low for one cycle. This keeps the host from treating a stale level as valid after it changes direction. The buffers and the execution of the commands live outside this block. The block sees only the buffer status flags and the command strobe.

Top module: `hostreq_flag`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters read mode (`mode_wr_o` = 0) and drives `req_o` = 1 after that edge. Once reset is released with `host_rw` already high, that level is not treated as a rising edge.
- R2: When `cmd_valid` is high with `cmd_op` equal to 0x10, 0x21, 0x31 or 0x40, `mode_wr_o` is 0 after the next clock edge.
- R3: When `cmd_valid` is high with `cmd_op` equal to 0x22 or 0x32, `mode_wr_o` is 1 after the next clock edge.
- R4: Any other opcode, and any opcode presented with `cmd_valid` low, leaves `mode_wr_o` unchanged.
- R5: In read mode, `req_o` after each clock edge equals `rdbuf_empty` as sampled at that edge. Low means data is ready for the host.
- R6: In write mode, `req_o` after each clock edge equals the inverse of `wrbuf_full` as sampled at that edge. High means there is room for the host to write.
- R7: At the first edge that samples `host_rw` high after it was low, `req_o` goes to 0 for that cycle, whatever R5 and R6 would give. Normal tracking resumes at the following edge.
- R8: At the edge that accepts a mode-changing command, `req_o` is already computed in the new mode (R5 or R6). `mode_wr_o` encodes the mode as 0 for read and 1 for write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_op | input | 8 | Command opcode |
| rdbuf_empty | input | 1 | Outbound (read) buffer empty flag |
| wrbuf_full | input | 1 | Inbound (write) buffer full flag |
| host_rw | input | 1 | Host bus direction, high for read |
| req_o | output | 1 | Registered host request line |
| mode_wr_o | output | 1 | Current mode, 1 = write |

## Verification
Three events can land on the same clock edge: a command that switches the mode, a change in the buffer flags, and a rising edge on `host_rw`. The bench sweeps every opcode, with and without the strobe, from both starting modes. It covers all eight combinations of the two buffer flags and the direction input.

A running model in the bench predicts the outcome. The rising edge overrides the request level. Otherwise the level follows the new mode on the same edge. Each cycle's mode and request values are compared with that model.

// File: rtl/hostreq_pkg.sv
package hostreq_pkg;
  localparam int OP_W     = 8;
  localparam int N_RD_OPS = 4;
  localparam int N_WR_OPS = 2;

  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } dir_mode_e;

  // Opcodes that place the port in host-read direction
  localparam logic [OP_W-1:0] RD_OPS [N_RD_OPS] = '{8'h10, 8'h21, 8'h31, 8'h40};
  // Opcodes that place the port in host-write direction
  localparam logic [OP_W-1:0] WR_OPS [N_WR_OPS] = '{8'h22, 8'h32};
endpackage

// File: rtl/hostreq_cmd_decode.sv
module hostreq_cmd_decode
  import hostreq_pkg::*;
(
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  output logic            set_rd_o,
  output logic            set_wr_o
);
  logic [N_RD_OPS-1:0] rd_hit;
  logic [N_WR_OPS-1:0] wr_hit;

  for (genvar i = 0; i < N_RD_OPS; i++) begin : g_rd
    assign rd_hit[i] = (op_i == RD_OPS[i]);
  end
  for (genvar j = 0; j < N_WR_OPS; j++) begin : g_wr
    assign wr_hit[j] = (op_i == WR_OPS[j]);
  end

  assign set_rd_o = valid_i & (|rd_hit);
  assign set_wr_o = valid_i & (|wr_hit);
endmodule

// File: rtl/hostreq_rw_edge.sv
module hostreq_rw_edge (
  input  logic clk,
  input  logic rst,
  input  logic rw_i,
  output logic rise_o
);
  logic rw_q;

  // During reset, track the live level so a high input at release is not an edge
  always_ff @(posedge clk) begin
    rw_q <= rw_i;
  end

  assign rise_o = rw_i & ~rw_q & ~rst;
endmodule

// File: rtl/hostreq_req_drive.sv
module hostreq_req_drive
  import hostreq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  dir_mode_e mode_i,
  input  logic      rise_i,
  input  logic      empty_i,
  input  logic      full_i,
  output logic      req_o
);
  logic req_d;

  always_comb begin
    if (rise_i)                req_d = 1'b0;
    else if (mode_i == MODE_WR) req_d = ~full_i;
    else                       req_d = empty_i;
  end

  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b1;
    else     req_o <= req_d;
  end
endmodule

// File: rtl/hostreq_flag.sv
module hostreq_flag
  import hostreq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            rdbuf_empty,
  input  logic            wrbuf_full,
  input  logic            host_rw,
  output logic            req_o,
  output logic            mode_wr_o
);
  logic      set_rd, set_wr, rw_rise;
  dir_mode_e mode_q, mode_d;

  hostreq_cmd_decode u_dec (
    .valid_i (cmd_valid),
    .op_i    (cmd_op),
    .set_rd_o(set_rd),
    .set_wr_o(set_wr)
  );

  hostreq_rw_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .rw_i  (host_rw),
    .rise_o(rw_rise)
  );

  always_comb begin
    mode_d = mode_q;
    if (set_wr)      mode_d = MODE_WR;
    else if (set_rd) mode_d = MODE_RD;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_RD;
    else     mode_q <= mode_d;
  end

  // Request is computed in the mode that takes effect at this edge
  hostreq_req_drive u_req (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_d),
    .rise_i (rw_rise),
    .empty_i(rdbuf_empty),
    .full_i (wrbuf_full),
    .req_o  (req_o)
  );

  assign mode_wr_o = (mode_q == MODE_WR);
endmodule

// File: rtl/hostreq_flag_chk.sv
module hostreq_flag_chk
  import hostreq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [OP_W-1:0] cmd_op,
  input logic            rdbuf_empty,
  input logic            wrbuf_full,
  input logic            host_rw,
  input logic            req_o,
  input logic            mode_wr_o
);
  logic rst_seen = 1'b0;
  logic rd_op, wr_op;

  always_comb begin
    rd_op = 1'b0;
    wr_op = 1'b0;
    for (int i = 0; i < N_RD_OPS; i++) if (cmd_op == RD_OPS[i]) rd_op = 1'b1;
    for (int j = 0; j < N_WR_OPS; j++) if (cmd_op == WR_OPS[j]) wr_op = 1'b1;
  end

  always @(posedge clk) begin
    if (rst_seen) begin
      p_reset_state_r1: assert (req_o == 1'b1 && mode_wr_o == 1'b0)
        else $error("reset state wrong");
    end
    rst_seen <= rst;
  end

  p_rd_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && rd_op) |=> !mode_wr_o);

  p_wr_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && wr_op) |=> mode_wr_o);

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || (!rd_op && !wr_op)) |=> $stable(mode_wr_o));

  p_rd_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && !mode_wr_o && !$rose(host_rw)) |=> (req_o == $past(rdbuf_empty)));

  p_wr_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && mode_wr_o && !$rose(host_rw)) |=> (req_o == !$past(wrbuf_full)));

  p_rise_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(host_rw) |=> !req_o);

  p_new_mode_req_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && wr_op && !$rose(host_rw)) |=> (req_o == !$past(wrbuf_full)));
endmodule

bind hostreq_flag hostreq_flag_chk u_chk (.*);

// File: tb/hostreq_flag_bench.sv
module hostreq_flag_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic       rdbuf_empty = 1'b1;
  logic       wrbuf_full = 1'b0;
  logic       host_rw = 1'b0;
  logic       req_o, mode_wr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Model state
  bit m_mode = 1'b0;
  bit m_rw   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hostreq_flag u_hostreq_flag (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rdbuf_empty(rdbuf_empty), .wrbuf_full(wrbuf_full), .host_rw(host_rw),
    .req_o(req_o), .mode_wr_o(mode_wr_o)
  );

  function automatic bit is_rd(input logic [7:0] op);
    return op == 8'h10 || op == 8'h21 || op == 8'h31 || op == 8'h40;
  endfunction
  function automatic bit is_wr(input logic [7:0] op);
    return op == 8'h22 || op == 8'h32;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b (op %02h v %0b)", tag, act, exp, cmd_op, cmd_valid);
    end
  endtask

  // Apply inputs for one cycle, update the model, check after the edge
  task automatic cyc(input bit v, input logic [7:0] op, input bit emp,
                     input bit ful, input bit rw);
    bit rise, chg, exp_req;
    string mtag, rtag;
    cmd_valid = v; cmd_op = op; rdbuf_empty = emp; wrbuf_full = ful; host_rw = rw;
    rise = rw && !m_rw;
    chg  = 1'b0;
    if (v && is_wr(op))      begin chg = (m_mode != 1'b1); m_mode = 1'b1; mtag = "R3"; end
    else if (v && is_rd(op)) begin chg = (m_mode != 1'b0); m_mode = 1'b0; mtag = "R2"; end
    else mtag = "R4";
    m_rw = rw;
    if (rise)        begin exp_req = 1'b0; rtag = "R7"; end
    else if (m_mode) begin exp_req = !ful; rtag = chg ? "R8" : "R6"; end
    else             begin exp_req = emp;  rtag = chg ? "R8" : "R5"; end
    @(posedge clk); #1;
    check(mode_wr_o, m_mode, mtag);
    check(req_o, exp_req, rtag);
  endtask

  initial begin
    // R1: reset with host_rw high, no spurious edge at release
    host_rw = 1'b1; rdbuf_empty = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(req_o, 1'b1, "R1");
    check(mode_wr_o, 1'b0, "R1");
    rst = 1'b0;
    m_mode = 1'b0; m_rw = 1'b1;
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);   // R1: level high at release is not a rise
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);

    for (int op = 0; op < 256; op++) begin
      for (int start = 0; start < 2; start++) begin
        for (int v = 0; v < 2; v++) begin
          for (int s = 0; s < 8; s++) begin
            cyc(1'b1, start ? 8'h32 : 8'h10, 1'b1, 1'b0, 1'b0);
            cyc(v[0], 8'(op), s[0], s[1], s[2]);
            cyc(1'b0, 8'hFF, s[1], s[0], 1'b0);
          end
        end
      end
    end

    // R7 then R6: rising edge in write mode, recovery on the following edge
    cyc(1'b1, 8'h22, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule